// File: doc/BRIEF.md
# USB Endpoint Handshake Control

This block keeps the control state of every endpoint of a USB device and decides which handshake answers each token. Software addresses one endpoint at a time and writes a command word. The word acts only where it holds ones. Its bits clear halt, set halt, arm the buffer, flush the endpoint, or reset the endpoint. Reads of the command word always give zero.

Each IN or OUT token names an endpoint and gets one of three answers: ACK, NAK or STALL. The answer is registered and appears one cycle after the token. A transaction-complete event advances the buffer state of the endpoint it names.

Endpoint 0 is the control endpoint, and a SETUP token on it is always accepted. Two parameter masks set the type of each endpoint: isochronous or not, and double-buffered or not.

A status port reads back the state of one selected endpoint:
- halt flag
- armed flag
- empty flag of the foreground buffer
- foreground buffer index
- last handshake

Top module: `usb_ep_handshake`

## Requirements
- R1: The command read port always returns zero. A written bit that is 0 has no effect, and so does any bit other than 7 (clear halt), 6 (set halt), 2 (arm), 1 (flush) and 0 (reset endpoint).
- R2: A non-isochronous endpoint with its halt flag set answers every IN or OUT token with STALL. Clear halt removes the flag. When set halt and clear halt arrive in one write, clear halt wins.
- R3: A non-isochronous endpoint that is neither halted nor armed answers with NAK.
- R4: An armed endpoint that is not halted answers with ACK. Halt takes priority over arming.
- R5: On a single-buffered non-isochronous endpoint, a completion event on an armed endpoint clears the armed flag, so the next token gets NAK.
- R6: On a double-buffered endpoint, each arm command readies the foreground buffer first and then the background buffer. Each completion releases the foreground buffer and toggles the foreground index. The endpoint stays armed while the new foreground buffer is ready.
- R7: An isochronous endpoint always answers with ACK and always reads as armed. Halt and arm commands leave it unchanged.
- R8: Flush clears the ready state of both buffers, sets both empty flags, sets the foreground index to 0 and sets the last-handshake field to 00. The halt flag is kept. Reset endpoint does the same and also clears the halt flag.
- R9: Each endpoint keeps its last handshake as 00 none, 01 ACK, 10 NAK or 11 STALL. The field reads 00 after reset.
- R10: A SETUP token always targets endpoint 0 and is answered with ACK, even when endpoint 0 is halted or not armed. It does not change the armed state.
- R11: A completion event on an armed endpoint sets the empty flag of the foreground buffer when the direction is IN. It clears that flag when the direction is OUT.
- R12: `hs_valid` and `hs_code` appear in the cycle after a token. Without a token, `hs_valid` is 0 and `hs_code` is 00.
- R13: A command changes only the endpoint it selects.
- R14: A token decides its handshake on the state before any command in the same cycle. Within one cycle, the token takes effect first, then the completion, then the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_ep | input | EP_W | Endpoint selected by the command |
| cmd_wdata | input | CMD_W | Command word, write-one-to-act |
| cmd_rdata | output | CMD_W | Command read value, always zero |
| tok_valid | input | 1 | Token event |
| tok_setup | input | 1 | Token is SETUP (endpoint 0) |
| tok_ep | input | EP_W | Token endpoint number |
| done_valid | input | 1 | Transaction-complete event |
| done_ep | input | EP_W | Endpoint of the completed transaction |
| done_in | input | 1 | Completed transaction direction, 1 = IN |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake: 01 ACK, 10 NAK, 11 STALL |
| stat_ep | input | EP_W | Endpoint selected for status read |
| stat_halt | output | 1 | Halt flag of the selected endpoint |
| stat_armed | output | 1 | Armed flag of the selected endpoint |
| stat_empty | output | 1 | Empty flag of the foreground buffer |
| stat_fg | output | 1 | Foreground buffer index |
| stat_last | output | 2 | Last handshake of the selected endpoint |

## Verification
The bench builds the block with four endpoints:
- endpoint 0 and endpoint 1 are single-buffered,
- endpoint 2 is double-buffered,
- endpoint 3 is isochronous.

This puts every buffer variant of the generate choice in one run, including the isochronous path that ignores halt and arm. With only four endpoints, random commands, tokens and completions often land on the same endpoint in the same cycle. That exercises the ordering in R14 and the interplay of arm and completion on both buffers of endpoint 2.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_ACK   = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_e;

   localparam int BIT_CLR_HALT = 7;
   localparam int BIT_SET_HALT = 6;
   localparam int BIT_ARM      = 2;
   localparam int BIT_FLUSH    = 1;
   localparam int BIT_RESET    = 0;

   typedef struct packed {
      logic clr_halt;
      logic set_halt;
      logic arm;
      logic flush;
      logic rst_ep;
   } ep_cmd_t;

endpackage

// File: rtl/usb_cmd_decode.sv
module usb_cmd_decode
   import usb_hs_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int EP_W   = 2,
   parameter int CMD_W  = 16
) (
   input  logic              wr_en,
   input  logic [EP_W-1:0]   wr_ep,
   input  logic [CMD_W-1:0]  wr_data,
   output ep_cmd_t           cmd,
   output logic [NUM_EP-1:0] cmd_hit
);

   localparam logic [CMD_W-1:0] USED_MASK =
      (CMD_W'(1) << BIT_CLR_HALT) | (CMD_W'(1) << BIT_SET_HALT) |
      (CMD_W'(1) << BIT_ARM) | (CMD_W'(1) << BIT_FLUSH) |
      (CMD_W'(1) << BIT_RESET);

   logic unused_rsvd;

   generate
      if (CMD_W <= BIT_CLR_HALT) begin : g_bad_width
         $error("usb_cmd_decode: CMD_W too narrow for the command bits");
      end
   endgenerate

   always_comb begin
      cmd.clr_halt = wr_data[BIT_CLR_HALT];
      cmd.set_halt = wr_data[BIT_SET_HALT];
      cmd.arm      = wr_data[BIT_ARM];
      cmd.flush    = wr_data[BIT_FLUSH];
      cmd.rst_ep   = wr_data[BIT_RESET];
   end

   assign unused_rsvd = ^(wr_data & ~USED_MASK);

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_hit
         assign cmd_hit[i] = wr_en && (wr_ep == EP_W'(i));
      end
   endgenerate

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
   import usb_hs_pkg::*;
#(
   parameter bit IS_ISO = 1'b0,
   parameter bit DBUF   = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cmd_hit,
   input  ep_cmd_t cmd,
   input  logic    tok_hit,
   input  hs_e     tok_hs,
   input  logic    done_hit,
   input  logic    done_in,
   output logic    halt,
   output logic    armed,
   output logic    empty_fg,
   output logic    fg,
   output hs_e     last_hs
);

   localparam bit TWO_BUF = IS_ISO || DBUF;

   logic       halt_q, n_halt;
   logic [1:0] rdy_q, n_rdy;
   logic [1:0] empty_q, n_empty;
   logic       fg_q, n_fg;
   hs_e        last_q, n_last;
   logic       wipe;

   assign wipe = cmd.flush || cmd.rst_ep;

   generate
      if (IS_ISO) begin : g_iso
         assign armed = 1'b1;
      end else begin : g_bulk
         assign armed = rdy_q[fg_q];
      end
   endgenerate

   always_comb begin
      n_halt  = halt_q;
      n_rdy   = rdy_q;
      n_empty = empty_q;
      n_fg    = fg_q;
      n_last  = last_q;
      if (tok_hit)
         n_last = tok_hs;
      if (done_hit && armed) begin
         n_empty[fg_q] = done_in;
         n_rdy[fg_q]   = 1'b0;
         if (TWO_BUF)
            n_fg = ~fg_q;
      end
      if (cmd_hit) begin
         if (wipe) begin
            n_rdy   = 2'b00;
            n_empty = 2'b11;
            n_fg    = 1'b0;
            n_last  = HS_NONE;
         end
         if (!IS_ISO) begin
            if (cmd.rst_ep || cmd.clr_halt)
               n_halt = 1'b0;
            else if (cmd.set_halt)
               n_halt = 1'b1;
            if (cmd.arm && !wipe) begin
               if (!n_rdy[n_fg])
                  n_rdy[n_fg] = 1'b1;
               else if (TWO_BUF)
                  n_rdy[~n_fg] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         rdy_q   <= 2'b00;
         empty_q <= 2'b11;
         fg_q    <= 1'b0;
         last_q  <= HS_NONE;
      end else begin
         halt_q  <= n_halt;
         rdy_q   <= n_rdy;
         empty_q <= n_empty;
         fg_q    <= n_fg;
         last_q  <= n_last;
      end
   end

   assign halt     = halt_q;
   assign empty_fg = empty_q[fg_q];
   assign fg       = fg_q;
   assign last_hs  = last_q;

   // R2: clear halt beats set halt in one write
   generate
      if (!IS_ISO) begin : g_halt_chk
         p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_hit && cmd.set_halt && cmd.clr_halt |=> !halt);
      end
      if (!IS_ISO && !DBUF) begin : g_single_chk
         p_done_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
            done_hit && armed && !(cmd_hit && cmd.arm) |=> !armed);
      end
   endgenerate

   p_flush_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && wipe |=> empty_fg && !fg && (last_hs == HS_NONE) && (IS_ISO || !armed));

   p_reset_ep_unhalts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && cmd.rst_ep |=> !halt);

endmodule

// File: rtl/usb_hs_select.sv
module usb_hs_select
   import usb_hs_pkg::*;
#(
   parameter int              NUM_EP   = 4,
   parameter int              EP_W     = 2,
   parameter logic [NUM_EP-1:0] ISO_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   input  logic              tok_setup,
   input  logic [EP_W-1:0]   tok_ep,
   input  logic [NUM_EP-1:0] halt_vec,
   input  logic [NUM_EP-1:0] armed_vec,
   output logic [EP_W-1:0]   eff_ep,
   output hs_e               hs_now,
   output logic              hs_valid,
   output logic [1:0]        hs_code
);

   always_comb begin
      eff_ep = tok_setup ? '0 : tok_ep;
      if (tok_setup)
         hs_now = HS_ACK;
      else if (ISO_MASK[eff_ep])
         hs_now = HS_ACK;
      else if (halt_vec[eff_ep])
         hs_now = HS_STALL;
      else if (armed_vec[eff_ep])
         hs_now = HS_ACK;
      else
         hs_now = HS_NAK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_valid <= 1'b0;
         hs_code  <= HS_NONE;
      end else begin
         hs_valid <= tok_valid;
         hs_code  <= tok_valid ? hs_now : HS_NONE;
      end
   end

   p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |=> hs_valid && (hs_code != HS_NONE));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |=> !hs_valid && (hs_code == HS_NONE));

   p_setup_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && tok_setup |=> hs_code == HS_ACK);

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
   import usb_hs_pkg::*;
#(
   parameter int                    NUM_EP    = 4,
   parameter int                    CMD_W     = 16,
   parameter logic [NUM_EP-1:0]     ISO_MASK  = 4'b1000,
   parameter logic [NUM_EP-1:0]     DBUF_MASK = 4'b0100,
   localparam int                   EP_W      = $clog2(NUM_EP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [EP_W-1:0]  cmd_ep,
   input  logic [CMD_W-1:0] cmd_wdata,
   output logic [CMD_W-1:0] cmd_rdata,
   input  logic             tok_valid,
   input  logic             tok_setup,
   input  logic [EP_W-1:0]  tok_ep,
   input  logic             done_valid,
   input  logic [EP_W-1:0]  done_ep,
   input  logic             done_in,
   output logic             hs_valid,
   output logic [1:0]       hs_code,
   input  logic [EP_W-1:0]  stat_ep,
   output logic             stat_halt,
   output logic             stat_armed,
   output logic             stat_empty,
   output logic             stat_fg,
   output logic [1:0]       stat_last
);

   generate
      if (NUM_EP < 2 || NUM_EP != (1 << EP_W)) begin : g_bad_count
         $error("usb_ep_handshake: NUM_EP must be a power of two, at least 2");
      end
      if (ISO_MASK[0]) begin : g_bad_ep0
         $error("usb_ep_handshake: endpoint 0 must be a control endpoint");
      end
   endgenerate

   ep_cmd_t           cmd;
   logic [NUM_EP-1:0] cmd_hit;
   logic [NUM_EP-1:0] halt_vec, armed_vec, empty_vec, fg_vec;
   hs_e               last_arr [NUM_EP];
   logic [EP_W-1:0]   eff_ep;
   hs_e               hs_now;

   assign cmd_rdata = '0;

   usb_cmd_decode #(.NUM_EP(NUM_EP), .EP_W(EP_W), .CMD_W(CMD_W)) u_dec (
      .wr_en   (cmd_we),
      .wr_ep   (cmd_ep),
      .wr_data (cmd_wdata),
      .cmd     (cmd),
      .cmd_hit (cmd_hit)
   );

   usb_hs_select #(.NUM_EP(NUM_EP), .EP_W(EP_W), .ISO_MASK(ISO_MASK)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_valid (tok_valid),
      .tok_setup (tok_setup),
      .tok_ep    (tok_ep),
      .halt_vec  (halt_vec),
      .armed_vec (armed_vec),
      .eff_ep    (eff_ep),
      .hs_now    (hs_now),
      .hs_valid  (hs_valid),
      .hs_code   (hs_code)
   );

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         usb_ep_ctrl #(.IS_ISO(ISO_MASK[i]), .DBUF(DBUF_MASK[i])) u_ep (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_hit  (cmd_hit[i]),
            .cmd      (cmd),
            .tok_hit  (tok_valid && (eff_ep == EP_W'(i))),
            .tok_hs   (hs_now),
            .done_hit (done_valid && (done_ep == EP_W'(i))),
            .done_in  (done_in),
            .halt     (halt_vec[i]),
            .armed    (armed_vec[i]),
            .empty_fg (empty_vec[i]),
            .fg       (fg_vec[i]),
            .last_hs  (last_arr[i])
         );
      end
   endgenerate

   assign stat_halt  = halt_vec[stat_ep];
   assign stat_armed = armed_vec[stat_ep];
   assign stat_empty = empty_vec[stat_ep];
   assign stat_fg    = fg_vec[stat_ep];
   assign stat_last  = last_arr[stat_ep];

   p_stall_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_setup && !ISO_MASK[tok_ep] && halt_vec[tok_ep]
      |=> hs_code == HS_STALL);

   p_nak_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_setup && !ISO_MASK[tok_ep] && !halt_vec[tok_ep] && !armed_vec[tok_ep]
      |=> hs_code == HS_NAK);

   p_iso_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_setup && ISO_MASK[tok_ep] |=> hs_code == HS_ACK);

endmodule

// File: tb/usb_ep_handshake_test.sv
`timescale 1ns/10ps
module usb_ep_handshake_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [1:0]  cmd_ep = '0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] cmd_rdata;
   logic        tok_valid = 1'b0, tok_setup = 1'b0;
   logic [1:0]  tok_ep = '0;
   logic        done_valid = 1'b0, done_in = 1'b0;
   logic [1:0]  done_ep = '0;
   logic        hs_valid;
   logic [1:0]  hs_code;
   logic [1:0]  stat_ep = '0;
   logic        stat_halt, stat_armed, stat_empty, stat_fg;
   logic [1:0]  stat_last;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   usb_ep_handshake uut (.*);

   // bench model: ep0/ep1 single, ep2 double-buffered, ep3 isochronous
   bit       m_halt  [4];
   bit [1:0] m_rdy   [4];
   bit [1:0] m_empty [4];
   bit       m_fg    [4];
   bit [1:0] m_last  [4];

   function automatic bit is_iso(int e);  return e == 3; endfunction
   function automatic bit two_buf(int e); return e >= 2; endfunction
   function automatic bit m_armed(int e);
      return is_iso(e) ? 1'b1 : m_rdy[e][m_fg[e]];
   endfunction
   function automatic bit [1:0] exp_hs(int e, bit su);
      if (su || is_iso(e)) return 2'b01;
      if (m_halt[e])       return 2'b11;
      if (m_armed(e))      return 2'b01;
      return 2'b10;
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic m_reset();
      for (int e = 0; e < 4; e++) begin
         m_halt[e] = 0; m_rdy[e] = 0; m_empty[e] = 2'b11; m_fg[e] = 0; m_last[e] = 0;
      end
   endtask

   task automatic check_status();
      for (int e = 0; e < 4; e++) begin
         stat_ep = e[1:0];
         #0.2;
         chk("R2 halt",   16'(stat_halt),  16'(m_halt[e]));
         chk("R5 armed",  16'(stat_armed), 16'(m_armed(e)));
         chk("R11 empty", 16'(stat_empty), 16'(m_empty[e][m_fg[e]]));
         chk("R6 fg",     16'(stat_fg),    16'(m_fg[e]));
         chk("R9 last",   16'(stat_last),  16'(m_last[e]));
      end
   endtask

   task automatic step(bit we, bit [1:0] cep, bit [15:0] wd,
                       bit tv, bit su, bit [1:0] tep,
                       bit dv, bit [1:0] dep, bit din);
      bit [1:0] eh;
      int       te;
      string    tg;
      @(negedge clk);
      cmd_we = we; cmd_ep = cep; cmd_wdata = wd;
      tok_valid = tv; tok_setup = su; tok_ep = tep;
      done_valid = dv; done_ep = dep; done_in = din;
      te = su ? 0 : int'(tep);
      eh = exp_hs(te, su);
      if (su) tg = "R10 setup";
      else if (is_iso(te)) tg = "R7 iso";
      else if (eh == 2'b11) tg = "R2 stall";
      else if (eh == 2'b10) tg = "R3 nak";
      else tg = "R4 ack";
      @(posedge clk);
      #1;
      cmd_we = 0; tok_valid = 0; tok_setup = 0; done_valid = 0;
      chk("R12 valid", 16'(hs_valid), 16'(tv));
      chk(tv ? tg : "R12 idle", 16'(hs_code), tv ? 16'(eh) : 16'h0);
      chk("R1 rdata", cmd_rdata, 16'h0);
      // model update: token, then completion, then command (R14)
      if (tv) m_last[te] = eh;
      if (dv && m_armed(dep)) begin
         m_empty[dep][m_fg[dep]] = din;
         m_rdy[dep][m_fg[dep]] = 0;
         if (two_buf(dep)) m_fg[dep] = ~m_fg[dep];
      end
      if (we) begin
         bit wipe;
         wipe = wd[1] | wd[0];
         if (wipe) begin
            m_rdy[cep] = 0; m_empty[cep] = 2'b11; m_fg[cep] = 0; m_last[cep] = 0;
         end
         if (!is_iso(cep)) begin
            if (wd[0] || wd[7]) m_halt[cep] = 0;
            else if (wd[6]) m_halt[cep] = 1;
            if (wd[2] && !wipe) begin
               if (!m_rdy[cep][m_fg[cep]]) m_rdy[cep][m_fg[cep]] = 1;
               else if (two_buf(cep)) m_rdy[cep][~m_fg[cep]] = 1;
            end
         end
      end
      check_status();
   endtask

   task automatic wr(bit [1:0] e, bit [15:0] d); step(1, e, d, 0, 0, 0, 0, 0, 0); endtask
   task automatic tok(bit [1:0] e);             step(0, 0, 0, 1, 0, e, 0, 0, 0); endtask
   task automatic fin(bit [1:0] e, bit din);    step(0, 0, 0, 0, 0, 0, 1, e, din); endtask
   task automatic peek(bit [1:0] e); stat_ep = e; #0.1; endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #0.5;
      check_status();                      // R9 reset state
      chk("R12 reset valid", 16'(hs_valid), 16'h0);

      tok(1);                              // R3 NAK when not armed
      chk("R3 nak ep1", 16'(hs_code), 16'h2);
      wr(1, 16'hFF38);                     // R1 reserved bits only
      tok(1);
      chk("R1 no effect", 16'(hs_code), 16'h2);
      wr(1, 16'h0004);                     // R4 arm
      tok(1);
      chk("R4 armed ack", 16'(hs_code), 16'h1);
      fin(1, 0);                           // R5 / R11
      peek(1);
      chk("R5 disarmed", 16'(stat_armed), 16'h0);
      chk("R11 out fills", 16'(stat_empty), 16'h0);
      tok(1);
      chk("R5 nak after done", 16'(hs_code), 16'h2);
      wr(1, 16'h0040);
      wr(1, 16'h0004);
      tok(1);
      chk("R4 halt beats arm", 16'(hs_code), 16'h3);
      peek(0);
      chk("R13 ep0 untouched", 16'(stat_halt), 16'h0);
      wr(1, 16'h00C0);
      peek(1);
      chk("R2 clear wins", 16'(stat_halt), 16'h0);

      wr(2, 16'h0004); wr(2, 16'h0004);    // R6 both buffers ready
      fin(2, 1);
      peek(2);
      chk("R6 swapped", 16'(stat_fg), 16'h1);
      chk("R6 still armed", 16'(stat_armed), 16'h1);
      fin(2, 1);
      peek(2);
      chk("R6 back to 0", 16'(stat_fg), 16'h0);
      chk("R6 drained", 16'(stat_armed), 16'h0);

      wr(3, 16'h0044);                     // R7 iso ignores halt/arm
      peek(3);
      chk("R7 no halt", 16'(stat_halt), 16'h0);
      tok(3);
      chk("R7 ack", 16'(hs_code), 16'h1);

      wr(2, 16'h0004); fin(2, 0); wr(2, 16'h0040); tok(2);
      wr(2, 16'h0002);                     // R8 flush keeps halt
      peek(2);
      chk("R8 empty", 16'(stat_empty), 16'h1);
      chk("R8 fg", 16'(stat_fg), 16'h0);
      chk("R8 last", 16'(stat_last), 16'h0);
      chk("R8 halt kept", 16'(stat_halt), 16'h1);
      wr(2, 16'h0001);
      peek(2);
      chk("R8 reset unhalts", 16'(stat_halt), 16'h0);

      wr(0, 16'h0040);                     // R10 setup on halted ep0
      step(0, 0, 0, 1, 1, 2'd2, 0, 0, 0);
      chk("R10 setup ack", 16'(hs_code), 16'h1);
      wr(0, 16'h0080);

      wr(1, 16'h0004);                     // R14 token + flush same cycle
      step(1, 1, 16'h0002, 1, 0, 1, 0, 0, 0);
      chk("R14 pre-state ack", 16'(hs_code), 16'h1);
      peek(1);
      chk("R14 flush last", 16'(stat_last), 16'h0);

      void'($urandom(32'd4242));
      for (int i = 0; i < 3000; i++) begin
         bit [15:0] wd;
         int        k;
         k = $urandom_range(0, 9);
         case (k)
            0: wd = 16'h0040; 1: wd = 16'h0080; 2: wd = 16'h00C0;
            3: wd = 16'h0002; 4: wd = 16'h0001; 5: wd = 16'h0044;
            6: wd = 16'h0006; 7: wd = 16'($urandom());
            default: wd = 16'h0004;
         endcase
         step($urandom_range(0, 2) == 0, 2'($urandom()), wd,
              $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0, 2'($urandom()),
              $urandom_range(0, 2) == 0, 2'($urandom()), 1'($urandom()));
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule